// File: doc/BRIEF.md
# Sorting Duplicate-Trap Shuffle Front End for an 8-Port Banyan

This block prepares one slot vector per clock for a self-routing 8x8 banyan fabric. Each of the eight input slots either is empty or holds a cell made of a 3-bit output address and a payload. The block orders the valid cells by address, keeps one cell for each address, and moves the kept cells to the lowest positions. It then interleaves the two halves of the vector. Any vector that leaves the block can cross the banyan with no internal collisions.

Cells that lose to an earlier cell with the same address leave on a separate rejected vector, with their payloads. Upstream logic can use that vector to offer them again. The datapath is pipelined and has a fixed latency. A new vector can enter on every clock edge.

Top module: `stq_front_end`

## Requirements
- R1: Among forwarded cells, the destinations taken in compacted order (before the shuffle) rise strictly, and every empty slot comes after every forwarded cell.
- R2: For each destination present in an input vector, exactly one cell is forwarded. No two forwarded cells in one output vector share a destination.
- R3: The forwarded cells fill compacted positions 0 to k-1, where k is the number of distinct destinations in the input vector. No empty slot sits between two forwarded cells.
- R4: The output is the perfect shuffle of the compacted list. Output slot 2m takes compacted entry m and output slot 2m+1 takes compacted entry m+4, for m = 0..3. For example, the compacted list {2, 3, empty x6} leaves as 2, empty, 3, empty x5.
- R5: Each forwarded cell carries the payload of an input cell with the same destination. A payload never changes slot except together with its destination.
- R6: For a destination that appears c > 0 times, c-1 cells show up on the rejected outputs with their payloads, in the same cycle as the forwarded vector. Forwarded plus rejected cells hold exactly the input's payloads.
- R7: An input vector shows up at the outputs exactly 8 rising clock edges after it is sampled. Consecutive vectors may arrive on back-to-back edges.
- R8: While reset is high, and until the first vector sampled after reset reaches the output, all forwarded and rejected valid flags are zero, whatever the inputs are.
- R9: The destination and payload bits of an input slot whose valid flag is 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 8 | Slot valid flags, bit s for slot s |
| in_dst | input | 24 | Slot destinations, slot s at bits 3s+2..3s |
| in_pay | input | 64 | Slot payloads, slot s at bits 8s+7..8s |
| out_vld | output | 8 | Forwarded slot valid flags |
| out_dst | output | 24 | Forwarded destinations, same packing as in_dst |
| out_pay | output | 64 | Forwarded payloads, same packing as in_pay |
| rej_vld | output | 8 | Rejected slot valid flags |
| rej_dst | output | 24 | Rejected destinations |
| rej_pay | output | 64 | Rejected payloads |

## Verification
Some properties hold for every output vector on its own, and the checker tests these on every cycle. They are the shape of the forwarded vector (R1, R3, R4, seen by undoing the shuffle), the uniqueness of forwarded destinations (R2), and the rule that each rejected cell has a forwarded cell with the same destination (R6). Other properties tie an output back to the input vector that produced it, and only the bench's scenarios can show them. These are the exact set of destinations, payload conservation and payload pairing (R5, R6), the eight-edge latency with back-to-back vectors (R7), reset behaviour under garbage input (R8), and the fact that fields of empty slots are ignored (R9). The scenarios include an all-same-destination vector, a fully reversed vector and the two-survivor case.

// File: rtl/stq_pkg.sv
package stq_pkg;
    localparam int SLOTS       = 8;
    localparam int LOG2_SLOTS  = $clog2(SLOTS);
    localparam int HALF        = SLOTS / 2;
    localparam int DST_W       = LOG2_SLOTS;
    localparam int PAY_W       = 8;
    localparam int SORT_LAYERS = LOG2_SLOTS * (LOG2_SLOTS + 1) / 2;
    localparam int LATENCY     = SORT_LAYERS + 2;

    typedef struct packed {
        logic             vld;
        logic [DST_W-1:0] dst;
        logic [PAY_W-1:0] pay;
    } cell_t;

    typedef cell_t [SLOTS-1:0] vec_t;

    // Empty slots rank above every valid cell
    function automatic logic [DST_W:0] sort_key(cell_t c);
        return {~c.vld, c.dst};
    endfunction

    // Span of the merge phase that owns sorting layer idx
    function automatic int layer_k(int idx);
        int n;
        int res;
        n   = 0;
        res = 2;
        for (int p = 1; p <= LOG2_SLOTS; p++) begin
            for (int q = p; q >= 1; q--) begin
                if (n == idx) res = 1 << p;
                n++;
            end
        end
        return res;
    endfunction

    // Partner distance inside sorting layer idx
    function automatic int layer_j(int idx);
        int n;
        int res;
        n   = 0;
        res = 1;
        for (int p = 1; p <= LOG2_SLOTS; p++) begin
            for (int q = p; q >= 1; q--) begin
                if (n == idx) res = 1 << (q - 1);
                n++;
            end
        end
        return res;
    endfunction

    // Interleave lower and upper halves
    function automatic vec_t perfect_shuffle(vec_t v);
        vec_t r;
        for (int m = 0; m < HALF; m++) begin
            r[2*m]   = v[m];
            r[2*m+1] = v[m+HALF];
        end
        return r;
    endfunction
endpackage

// File: rtl/stq_sort_layer.sv
module stq_sort_layer
    import stq_pkg::*;
#(
    parameter int K = 2,
    parameter int J = 1
) (
    input  vec_t d,
    output vec_t q
);
    always_comb begin
        q = d;
        for (int i = 0; i < SLOTS; i++) begin
            int  p;
            logic asc;
            logic swap;
            p   = i ^ J;
            asc = ((i & K) == 0);
            if (p > i) begin
                swap = asc ? (sort_key(d[i]) > sort_key(d[p]))
                           : (sort_key(d[i]) < sort_key(d[p]));
                if (swap) begin
                    q[i] = d[p];
                    q[p] = d[i];
                end
            end
        end
    end
endmodule

// File: rtl/stq_sorter.sv
module stq_sorter
    import stq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t in_v,
    output vec_t out_v
);
    for (genvar g = 0; g < SORT_LAYERS; g++) begin : g_layer
        vec_t src;
        vec_t nxt;
        vec_t q_r;
        if (g == 0) begin : g_first
            assign src = in_v;
        end else begin : g_rest
            assign src = g_layer[g-1].q_r;
        end
        stq_sort_layer #(.K(layer_k(g)), .J(layer_j(g))) u_layer (
            .d(src),
            .q(nxt)
        );
        always_ff @(posedge clk) begin
            if (rst) q_r <= '0;
            else     q_r <= nxt;
        end
    end

    assign out_v = g_layer[SORT_LAYERS-1].q_r;
endmodule

// File: rtl/stq_trap_compact.sv
module stq_trap_compact
    import stq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t srt,
    output vec_t fwd_q,
    output vec_t rej_q
);
    logic [SLOTS-1:0] dup;
    vec_t             fwd_c;
    vec_t             rej_c;

    always_comb begin
        dup[0] = 1'b0;
        for (int i = 1; i < SLOTS; i++) begin
            dup[i] = srt[i].vld && srt[i-1].vld && (srt[i-1].dst == srt[i].dst);
        end
    end

    always_comb begin
        logic [LOG2_SLOTS:0] cnt;
        cnt   = '0;
        fwd_c = '0;
        rej_c = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (dup[i]) begin
                rej_c[i] = srt[i];
            end else if (srt[i].vld) begin
                fwd_c[cnt[LOG2_SLOTS-1:0]] = srt[i];
                cnt = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q <= '0;
            rej_q <= '0;
        end else begin
            fwd_q <= fwd_c;
            rej_q <= rej_c;
        end
    end
endmodule

// File: rtl/stq_front_end.sv
module stq_front_end
    import stq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SLOTS-1:0]         in_vld,
    input  logic [SLOTS*DST_W-1:0]   in_dst,
    input  logic [SLOTS*PAY_W-1:0]   in_pay,
    output logic [SLOTS-1:0]         out_vld,
    output logic [SLOTS*DST_W-1:0]   out_dst,
    output logic [SLOTS*PAY_W-1:0]   out_pay,
    output logic [SLOTS-1:0]         rej_vld,
    output logic [SLOTS*DST_W-1:0]   rej_dst,
    output logic [SLOTS*PAY_W-1:0]   rej_pay
);
    vec_t in_v;
    vec_t sorted_v;
    vec_t fwd_v;
    vec_t rej_v;
    vec_t out_r;
    vec_t rej_r;

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            in_v[s].vld = in_vld[s];
            in_v[s].dst = in_dst[s*DST_W +: DST_W];
            in_v[s].pay = in_pay[s*PAY_W +: PAY_W];
        end
    end

    stq_sorter u_sort (
        .clk  (clk),
        .rst  (rst),
        .in_v (in_v),
        .out_v(sorted_v)
    );

    stq_trap_compact u_trap (
        .clk  (clk),
        .rst  (rst),
        .srt  (sorted_v),
        .fwd_q(fwd_v),
        .rej_q(rej_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_r <= '0;
            rej_r <= '0;
        end else begin
            out_r <= perfect_shuffle(fwd_v);
            rej_r <= rej_v;
        end
    end

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            out_vld[s]               = out_r[s].vld;
            out_dst[s*DST_W +: DST_W] = out_r[s].dst;
            out_pay[s*PAY_W +: PAY_W] = out_r[s].pay;
            rej_vld[s]               = rej_r[s].vld;
            rej_dst[s*DST_W +: DST_W] = rej_r[s].dst;
            rej_pay[s*PAY_W +: PAY_W] = rej_r[s].pay;
        end
    end
endmodule

// File: rtl/stq_checker.sv
module stq_checker
    import stq_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [SLOTS-1:0]       out_vld,
    input logic [SLOTS*DST_W-1:0] out_dst,
    input logic [SLOTS-1:0]       rej_vld,
    input logic [SLOTS*DST_W-1:0] rej_dst
);
    logic [SLOTS-1:0]       cv;
    logic [DST_W-1:0]       cd [SLOTS];
    logic                   prefix_ok;
    logic                   ascend_ok;
    logic                   unique_ok;
    logic                   rej_ok;

    // Undo the interleave so the compacted order can be inspected
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            int m;
            m = (s % 2 == 0) ? (s / 2) : (s / 2 + HALF);
            cv[m] = out_vld[s];
            cd[m] = out_dst[s*DST_W +: DST_W];
        end
    end

    always_comb begin
        prefix_ok = 1'b1;
        ascend_ok = 1'b1;
        for (int m = 1; m < SLOTS; m++) begin
            if (cv[m] && !cv[m-1]) prefix_ok = 1'b0;
            if (cv[m] && cv[m-1] && !(cd[m-1] < cd[m])) ascend_ok = 1'b0;
        end
    end

    always_comb begin
        unique_ok = 1'b1;
        for (int a = 0; a < SLOTS; a++) begin
            for (int b = a + 1; b < SLOTS; b++) begin
                if (out_vld[a] && out_vld[b] &&
                    out_dst[a*DST_W +: DST_W] == out_dst[b*DST_W +: DST_W])
                    unique_ok = 1'b0;
            end
        end
    end

    always_comb begin
        rej_ok = 1'b1;
        for (int r = 0; r < SLOTS; r++) begin
            logic hit;
            hit = 1'b0;
            for (int t = 0; t < SLOTS; t++) begin
                if (out_vld[t] && out_dst[t*DST_W +: DST_W] == rej_dst[r*DST_W +: DST_W])
                    hit = 1'b1;
            end
            if (rej_vld[r] && !hit) rej_ok = 1'b0;
        end
    end

    AST_FWD_ASCEND:       assert property (@(posedge clk) disable iff (rst) ascend_ok); // R1
    AST_FWD_UNIQUE:       assert property (@(posedge clk) disable iff (rst) unique_ok); // R2
    AST_SHUF_PREFIX:      assert property (@(posedge clk) disable iff (rst) prefix_ok); // R4
    AST_REJ_HAS_SURVIVOR: assert property (@(posedge clk) disable iff (rst) rej_ok);    // R6
    AST_REJ_LE_FWD:       assert property (@(posedge clk) disable iff (rst)
                              ($countones(rej_vld) + $countones(out_vld)) <= SLOTS);   // R6
endmodule

bind stq_front_end stq_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .out_vld(out_vld),
    .out_dst(out_dst),
    .rej_vld(rej_vld),
    .rej_dst(rej_dst)
);

// File: tb/sim_stq_front_end.sv
module sim_stq_front_end;
    localparam int N     = 8;
    localparam int LAT   = 8;
    localparam int TOTAL = 180;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  in_vld = '0;
    logic [3*N-1:0] in_dst = '0;
    logic [8*N-1:0] in_pay = '0;
    logic [N-1:0]  out_vld;
    logic [3*N-1:0] out_dst;
    logic [8*N-1:0] out_pay;
    logic [N-1:0]  rej_vld;
    logic [3*N-1:0] rej_dst;
    logic [8*N-1:0] rej_pay;

    int n_checks = 0;
    int n_fails  = 0;

    logic [N-1:0] hv [16];
    logic [2:0]   hd [16][N];
    logic [7:0]   hp [16][N];

    always #5 clk = ~clk;

    stq_front_end u0 (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_dst(in_dst), .in_pay(in_pay),
        .out_vld(out_vld), .out_dst(out_dst), .out_pay(out_pay),
        .rej_vld(rej_vld), .rej_dst(rej_dst), .rej_pay(rej_pay)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected forward/rejected content for the vector stored at slot h
    task automatic check_vec(input int h);
        int          cnt [8];
        int          sum_in [8];
        int          sum_out [8];
        int          rcnt [8];
        logic [2:0]  lst [N];
        int          k;
        logic [N-1:0] ev;
        logic [2:0]  ed [N];
        logic        pay_ok;
        logic        dst_ok;
        logic        rej_ok;
        for (int d = 0; d < 8; d++) begin cnt[d] = 0; sum_in[d] = 0; sum_out[d] = 0; rcnt[d] = 0; end
        for (int s = 0; s < N; s++) if (hv[h][s]) begin
            cnt[hd[h][s]]++;
            sum_in[hd[h][s]] += hp[h][s];
        end
        k = 0;
        for (int d = 0; d < 8; d++) if (cnt[d] > 0) begin lst[k] = 3'(d); k++; end
        ev = '0;
        for (int s = 0; s < N; s++) ed[s] = '0;
        for (int m = 0; m < k; m++) begin
            int s;
            s = (m < N/2) ? 2*m : 2*(m - N/2) + 1;
            ev[s] = 1'b1;
            ed[s] = lst[m];
        end
        // R3 R4: valid pattern is the shuffled prefix of length k
        chk(out_vld == ev, "R3/R4 valid pattern", int'(out_vld), int'(ev));
        dst_ok = 1'b1;
        pay_ok = 1'b1;
        for (int s = 0; s < N; s++) if (out_vld[s]) begin
            logic found;
            if (out_dst[3*s +: 3] != ed[s]) dst_ok = 1'b0;
            found = 1'b0;
            for (int t = 0; t < N; t++)
                if (hv[h][t] && hd[h][t] == out_dst[3*s +: 3] && hp[h][t] == out_pay[8*s +: 8]) found = 1'b1;
            if (!found) pay_ok = 1'b0;
            sum_out[out_dst[3*s +: 3]] += out_pay[8*s +: 8];
        end
        // R1 R2: ascending unique destinations in compacted order
        chk(dst_ok, "R1/R2 destinations", int'(out_dst), 0);
        // R5: payload paired with its destination
        chk(pay_ok, "R5 payload pairing", int'(out_pay[31:0]), 0);
        for (int s = 0; s < N; s++) if (rej_vld[s]) begin
            rcnt[rej_dst[3*s +: 3]]++;
            sum_out[rej_dst[3*s +: 3]] += rej_pay[8*s +: 8];
        end
        rej_ok = 1'b1;
        for (int d = 0; d < 8; d++) begin
            int want;
            want = (cnt[d] > 0) ? cnt[d] - 1 : 0;
            if (rcnt[d] != want || sum_out[d] != sum_in[d]) rej_ok = 1'b0;
        end
        // R6: rejected counts and payload conservation
        chk(rej_ok, "R6 rejected cells", int'(rej_vld), 0);
    endtask

    task automatic make_vec(input int t);
        logic [N-1:0] v;
        logic [2:0]   d [N];
        logic [7:0]   p [N];
        for (int s = 0; s < N; s++) begin
            v[s] = 1'b0;
            d[s] = 3'($urandom);
            p[s] = 8'($urandom);   // junk in empty slots exercises R9
        end
        case (t)
            0: ;                                           // all empty
            1: begin v = 8'b0001_0110; d[1] = 3'd2; d[2] = 3'd2; d[4] = 3'd3; end
            2: begin v = '1; for (int s = 0; s < N; s++) d[s] = 3'd5; end
            3: begin v = '1; for (int s = 0; s < N; s++) d[s] = 3'(7 - s); end
            4: begin v = 8'b1000_0001; d[0] = 3'd7; d[7] = 3'd0; end
            default: begin
                for (int s = 0; s < N; s++) begin
                    v[s] = ($urandom % 10) < 6;
                    d[s] = (t % 2 == 0) ? 3'($urandom % 4) : 3'($urandom % 8);
                end
            end
        endcase
        for (int s = 0; s < N; s++) if (v[s]) p[s] = 8'(t * N + s);
        hv[t % 16] = v;
        for (int s = 0; s < N; s++) begin
            hd[t % 16][s] = d[s];
            hp[t % 16][s] = p[s];
            in_dst[3*s +: 3] = d[s];
            in_pay[8*s +: 8] = p[s];
        end
        in_vld = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        // R8: garbage on the inputs while reset is held
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_vld = 8'($urandom);
            in_dst = 24'($urandom);
            in_pay = {$urandom, $urandom};
            chk(out_vld == '0 && rej_vld == '0, "R8 outputs empty in reset",
                int'({out_vld, rej_vld}), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        for (int t = 0; t < TOTAL + LAT; t++) begin
            if (t > 0) @(negedge clk);
            if (t < LAT) begin
                // R7 R8: nothing emerges before eight edges have passed
                chk(out_vld == '0 && rej_vld == '0, "R7/R8 empty before latency",
                    int'({out_vld, rej_vld}), 0);
            end else begin
                check_vec((t - LAT) % 16);   // R7: vector t-8 appears now
            end
            if (t < TOTAL) make_vec(t);
            else begin in_vld = '0; in_dst = 24'($urandom); in_pay = {$urandom, $urandom}; end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule